// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider Chain

This block holds the programmable dividers of a frequency synthesizer. A reference divider splits the reference clock down by a ratio R and marks each reload with a pulse. A feedback pair works on the output clock of an external two-ratio prescaler. A main counter of length N sets the feedback period. A swallow counter holds the modulus-control line high for the first A of those N prescaler cycles. The loop therefore divides the oscillator by N·P + A, where P is the low prescaler ratio.

Software-side writes arrive in the reference clock domain. A write to the swallow/main word only stages that word. A later legal write to the reference ratio commits both words together. Each clock domain holds the committed value in a pending register. It moves that value into its live counter only when the counter reaches terminal count, so a count that is already running always finishes on its old ratio. The committed swallow/main word crosses to the feedback domain with a toggle, a two-flop synchronizer and an edge detector. The word itself is held steady from commit time until it is captured.

Each domain runs a two-state update machine:
- UPD_IDLE: no value is pending. The transition arm goes to UPD_ARMED when a commit arrives.
- UPD_ARMED: a value is pending. The transition apply returns to UPD_IDLE when the counter reloads and no new commit arrives in that cycle.
- If a commit arrives in the reload cycle, the transition reapply loads the old pending value and stays in UPD_ARMED with the newer one.

Top module: `pll_divider`

## Requirements
- R1: While reset is held, ref_pulse, fb_pulse, mod_ctl and an_err are all 0. After reset the ratios are R=1, N=1 and A=0. As a result, ref_pulse and fb_pulse are high in every cycle and mod_ctl stays low.
- R2: For a committed ratio R ≥ 5, ref_pulse is high for exactly one clk_ref cycle in every R cycles. For R=1 it is high in every cycle.
- R3: A write to wr_r whose value in wr_data[12:0] is 0, 2, 3 or 4 is ignored. The reference period does not change, and the staged swallow/main word is not committed.
- R4: A write to wr_an takes N from wr_data[17:7] and A from wr_data[6:0]. It only stages the word, and the feedback outputs do not change until a legal wr_r write follows. A staged N of 0 is used as 1. If wr_r and wr_an are strobed in the same cycle, wr_an is ignored.
- R5: With committed N and A, fb_pulse is high once every N clk_fb cycles. mod_ctl is high for exactly A cycles of each period, starting in the cycle in which fb_pulse is high.
- R6: A staged word with A > N sets an_err, and its A is clamped to N. mod_ctl is then high for all N cycles of each period. The next staged word with A ≤ N clears an_err.
- R7: A legal R committed in the middle of a reference count does not disturb that count: the current period ends on the old R, and every later period uses the new R.
- R8: After a commit, each feedback period uses either the old N and A together or the new N and A together, never a mix. The change happens only at a reload.
- R9: When several legal R values are committed before the reference counter reloads, the last one is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; also clocks the write strobes |
| rst_ref | input | 1 | Synchronous active-high reset, reference domain |
| wr_an | input | 1 | Stage the swallow/main word from wr_data |
| wr_r | input | 1 | Write R from wr_data[12:0] and commit all ratios |
| wr_data | input | 18 | Write data |
| ref_pulse | output | 1 | One-cycle pulse at each reference reload |
| an_err | output | 1 | Last staged A exceeded N |
| clk_fb | input | 1 | Prescaler output clock |
| rst_fb | input | 1 | Synchronous active-high reset, feedback domain |
| fb_pulse | output | 1 | One-cycle pulse at each feedback reload |
| mod_ctl | output | 1 | Prescaler modulus select, high selects P+1 |

## Verification
The hardest case to reach is a feedback ratio change that lands while a feedback period is running. The commit is made in the reference domain, and its timing relative to the feedback count is set by the synchronizer. The bench aligns to a feedback pulse and then issues the staging and commit writes in parallel with a monitor of six back-to-back feedback periods. The commit therefore arrives mid-count, and each measured period is compared with the old and new (N, A) pairs. The same approach is used in the reference domain: the bench writes one and two cycles after a pulse, then checks the length of the period that was already in progress.

// File: rtl/pll_div_pkg.sv
`timescale 1ns/1ps
package pll_div_pkg;
    parameter int unsigned R_W_DEF    = 13;
    parameter int unsigned N_W_DEF    = 11;
    parameter int unsigned A_W_DEF    = 7;
    parameter int unsigned R_MIN_MULT = 5;

    typedef enum logic [0:0] {
        UPD_IDLE  = 1'b0,
        UPD_ARMED = 1'b1
    } upd_state_t;
endpackage

// File: rtl/pll_div_cfg.sv
`timescale 1ns/1ps
module pll_div_cfg #(
    parameter int unsigned R_W = pll_div_pkg::R_W_DEF,
    parameter int unsigned N_W = pll_div_pkg::N_W_DEF,
    parameter int unsigned A_W = pll_div_pkg::A_W_DEF,
    localparam int unsigned D_W = N_W + A_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_an,
    input  logic           wr_r,
    input  logic [D_W-1:0] wr_data,
    output logic           an_err,
    output logic           commit,
    output logic [R_W-1:0] r_value,
    output logic [N_W-1:0] xfer_n,
    output logic [A_W-1:0] xfer_a,
    output logic           xfer_tog
);
    localparam int unsigned CW = (N_W > A_W) ? N_W : A_W;

    logic [R_W-1:0] r_field;
    logic [N_W-1:0] n_field, n_fix, stage_n;
    logic [A_W-1:0] a_field, a_fix, stage_a;
    logic           r_ok, r_take, an_take, a_over;

    // Field decode and legality of a reference ratio
    always_comb begin
        r_field = wr_data[R_W-1:0];
        n_field = wr_data[D_W-1:A_W];
        a_field = wr_data[A_W-1:0];
        r_ok    = (r_field == R_W'(1)) || (r_field >= R_W'(pll_div_pkg::R_MIN_MULT));
        r_take  = wr_r && r_ok;
        an_take = wr_an && !wr_r;
        n_fix   = (n_field == '0) ? N_W'(1) : n_field;
        a_over  = CW'(a_field) > CW'(n_fix);
        a_fix   = a_over ? A_W'(n_fix) : a_field;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_n  <= N_W'(1);
            stage_a  <= '0;
            an_err   <= 1'b0;
            r_value  <= R_W'(1);
            xfer_n   <= N_W'(1);
            xfer_a   <= '0;
            xfer_tog <= 1'b0;
            commit   <= 1'b0;
        end else begin
            commit <= r_take;
            if (r_take) begin
                r_value  <= r_field;
                xfer_n   <= stage_n;
                xfer_a   <= stage_a;
                xfer_tog <= ~xfer_tog;
            end else if (an_take) begin
                stage_n <= n_fix;
                stage_a <= a_fix;
                an_err  <= a_over;
            end
        end
    end
endmodule

// File: rtl/pll_div_ref_chain.sv
`timescale 1ns/1ps
module pll_div_ref_chain #(
    parameter int unsigned R_W = pll_div_pkg::R_W_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           commit,
    input  logic [R_W-1:0] r_new,
    output logic           pulse,
    output logic [R_W-1:0] r_active
);
    import pll_div_pkg::*;

    upd_state_t     state_q, state_d;
    logic [R_W-1:0] r_pend, cnt, ld_val;
    logic           terminal;

    always_comb begin
        terminal = (cnt == '0);
        ld_val   = (state_q == UPD_ARMED) ? r_pend : r_active;
    end

    // Next-state logic: arm, apply, reapply
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UPD_IDLE:  if (commit) state_d = UPD_ARMED;
            UPD_ARMED: if (terminal && !commit) state_d = UPD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= UPD_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_active <= R_W'(1);
            r_pend   <= R_W'(1);
            cnt      <= '0;
            pulse    <= 1'b0;
        end else begin
            pulse <= terminal;
            if (commit) r_pend <= r_new;
            if (terminal) begin
                r_active <= ld_val;
                cnt      <= ld_val - R_W'(1);
            end else begin
                cnt <= cnt - R_W'(1);
            end
        end
    end
endmodule

// File: rtl/pll_div_toggle_sync.sv
`timescale 1ns/1ps
module pll_div_toggle_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tog_in,
    output logic req
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], tog_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign req = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/pll_div_fb_chain.sv
`timescale 1ns/1ps
module pll_div_fb_chain #(
    parameter int unsigned N_W = pll_div_pkg::N_W_DEF,
    parameter int unsigned A_W = pll_div_pkg::A_W_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req,
    input  logic [N_W-1:0] n_new,
    input  logic [A_W-1:0] a_new,
    output logic           pulse,
    output logic           mod_ctl,
    output logic [N_W-1:0] n_active,
    output logic [A_W-1:0] a_active
);
    import pll_div_pkg::*;

    upd_state_t     state_q, state_d;
    logic [N_W-1:0] n_pend, n_cnt, ld_n;
    logic [A_W-1:0] a_pend, a_cnt, ld_a;
    logic           terminal;

    always_comb begin
        terminal = (n_cnt == '0);
        ld_n     = (state_q == UPD_ARMED) ? n_pend : n_active;
        ld_a     = (state_q == UPD_ARMED) ? a_pend : a_active;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UPD_IDLE:  if (req) state_d = UPD_ARMED;
            UPD_ARMED: if (terminal && !req) state_d = UPD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= UPD_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            n_active <= N_W'(1);
            a_active <= '0;
            n_pend   <= N_W'(1);
            a_pend   <= '0;
            n_cnt    <= '0;
            a_cnt    <= '0;
            pulse    <= 1'b0;
        end else begin
            pulse <= terminal;
            if (req) begin
                n_pend <= n_new;
                a_pend <= a_new;
            end
            if (terminal) begin
                n_active <= ld_n;
                a_active <= ld_a;
                n_cnt    <= ld_n - N_W'(1);
                a_cnt    <= ld_a;
            end else begin
                n_cnt <= n_cnt - N_W'(1);
                if (a_cnt != '0) a_cnt <= a_cnt - A_W'(1);
            end
        end
    end

    assign mod_ctl = (a_cnt != '0);
endmodule

// File: rtl/pll_divider.sv
`timescale 1ns/1ps
module pll_divider #(
    parameter int unsigned R_W = pll_div_pkg::R_W_DEF,
    parameter int unsigned N_W = pll_div_pkg::N_W_DEF,
    parameter int unsigned A_W = pll_div_pkg::A_W_DEF,
    localparam int unsigned D_W = N_W + A_W
) (
    input  logic           clk_ref,
    input  logic           rst_ref,
    input  logic           wr_an,
    input  logic           wr_r,
    input  logic [D_W-1:0] wr_data,
    output logic           ref_pulse,
    output logic           an_err,
    input  logic           clk_fb,
    input  logic           rst_fb,
    output logic           fb_pulse,
    output logic           mod_ctl
);
    logic           commit, xfer_tog, fb_req;
    logic [R_W-1:0] r_value, r_active;
    logic [N_W-1:0] xfer_n, n_active;
    logic [A_W-1:0] xfer_a, a_active;

    pll_div_cfg #(.R_W(R_W), .N_W(N_W), .A_W(A_W)) u_cfg (
        .clk(clk_ref), .rst(rst_ref), .wr_an(wr_an), .wr_r(wr_r),
        .wr_data(wr_data), .an_err(an_err), .commit(commit),
        .r_value(r_value), .xfer_n(xfer_n), .xfer_a(xfer_a),
        .xfer_tog(xfer_tog)
    );

    pll_div_ref_chain #(.R_W(R_W)) u_ref (
        .clk(clk_ref), .rst(rst_ref), .commit(commit), .r_new(r_value),
        .pulse(ref_pulse), .r_active(r_active)
    );

    pll_div_toggle_sync #(.STAGES(2)) u_sync (
        .clk(clk_fb), .rst(rst_fb), .tog_in(xfer_tog), .req(fb_req)
    );

    pll_div_fb_chain #(.N_W(N_W), .A_W(A_W)) u_fb (
        .clk(clk_fb), .rst(rst_fb), .req(fb_req), .n_new(xfer_n),
        .a_new(xfer_a), .pulse(fb_pulse), .mod_ctl(mod_ctl),
        .n_active(n_active), .a_active(a_active)
    );
endmodule

// File: rtl/pll_divider_chk.sv
`timescale 1ns/1ps
module pll_divider_chk #(
    parameter int unsigned R_W = pll_div_pkg::R_W_DEF,
    parameter int unsigned N_W = pll_div_pkg::N_W_DEF,
    parameter int unsigned A_W = pll_div_pkg::A_W_DEF
) (
    input logic           clk_ref,
    input logic           rst_ref,
    input logic           ref_pulse,
    input logic [R_W-1:0] r_active,
    input logic           clk_fb,
    input logic           rst_fb,
    input logic           fb_pulse,
    input logic           mod_ctl,
    input logic [N_W-1:0] n_active,
    input logic [A_W-1:0] a_active
);
    localparam int unsigned CW = (N_W > A_W) ? N_W : A_W;

    // R2
    ref_single_pulse_chk: assert property (@(posedge clk_ref) disable iff (rst_ref)
        (ref_pulse && r_active >= R_W'(5)) |=> !ref_pulse);

    // R3
    r_legal_chk: assert property (@(posedge clk_ref) disable iff (rst_ref)
        (r_active == R_W'(1)) || (r_active >= R_W'(5)));

    // R7
    r_switch_at_reload_chk: assert property (@(posedge clk_ref) disable iff (rst_ref)
        !$stable(r_active) |-> ref_pulse);

    // R8
    an_switch_at_reload_chk: assert property (@(posedge clk_fb) disable iff (rst_fb)
        (!$stable(n_active) || !$stable(a_active)) |-> fb_pulse);

    // R6
    a_clamped_chk: assert property (@(posedge clk_fb) disable iff (rst_fb)
        CW'(a_active) <= CW'(n_active));

    // R5
    mod_ctl_once_low_chk: assert property (@(posedge clk_fb) disable iff (rst_fb)
        !mod_ctl |=> (!mod_ctl || fb_pulse));
endmodule

bind pll_divider pll_divider_chk #(.R_W(R_W), .N_W(N_W), .A_W(A_W)) u_chk (
    .clk_ref(clk_ref), .rst_ref(rst_ref), .ref_pulse(ref_pulse),
    .r_active(r_active), .clk_fb(clk_fb), .rst_fb(rst_fb),
    .fb_pulse(fb_pulse), .mod_ctl(mod_ctl), .n_active(n_active),
    .a_active(a_active)
);

// File: tb/pll_divider_bench.sv
`timescale 1ns/1ps
module pll_divider_bench;
    logic        clk_ref = 1'b0, clk_fb = 1'b0;
    logic        rst_ref = 1'b1, rst_fb = 1'b1;
    logic        wr_an = 1'b0, wr_r = 1'b0;
    logic [17:0] wr_data = '0;
    logic        ref_pulse, an_err, fb_pulse, mod_ctl;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;

    always #2.5 clk_ref = ~clk_ref;
    always #3.5 clk_fb  = ~clk_fb;

    pll_divider u_pll_divider (
        .clk_ref(clk_ref), .rst_ref(rst_ref), .wr_an(wr_an), .wr_r(wr_r),
        .wr_data(wr_data), .ref_pulse(ref_pulse), .an_err(an_err),
        .clk_fb(clk_fb), .rst_fb(rst_fb), .fb_pulse(fb_pulse), .mod_ctl(mod_ctl)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_an(input int n, input int a);
        @(negedge clk_ref);
        wr_an = 1'b1; wr_data = {11'(n), 7'(a)};
        @(negedge clk_ref);
        wr_an = 1'b0;
    endtask

    task automatic write_r(input int r);
        @(negedge clk_ref);
        wr_r = 1'b1; wr_data = 18'(r);
        @(negedge clk_ref);
        wr_r = 1'b0;
    endtask

    task automatic wait_ref(input int n);
        repeat (n) @(negedge clk_ref);
    endtask

    task automatic wait_fb(input int n);
        repeat (n) @(negedge clk_fb);
    endtask

    task automatic ref_sync();
        do @(negedge clk_ref); while (!ref_pulse);
    endtask

    task automatic ref_period(output int per);
        per = 0;
        do begin per++; @(negedge clk_ref); end while (!ref_pulse);
    endtask

    task automatic fb_sync();
        do @(negedge clk_fb); while (!fb_pulse);
    endtask

    task automatic fb_period(output int per, output int mch);
        per = 0; mch = 0;
        do begin
            per++;
            if (mod_ctl) mch++;
            @(negedge clk_fb);
        end while (!fb_pulse);
    endtask

    task automatic expect_ref(input string req, input int r);
        int per;
        ref_sync();
        for (int i = 0; i < 2; i++) begin
            ref_period(per);
            check(req, "ref period", per, r);
        end
    endtask

    task automatic expect_fb(input string req, input int n, input int a);
        int per, mch;
        fb_sync();
        for (int i = 0; i < 2; i++) begin
            fb_period(per, mch);
            check(req, "fb period", per, n);
            check(req, "mod_ctl cycles", mch, a);
        end
    endtask

    task automatic t_reset();
        @(negedge clk_ref);
        check("R1", "ref_pulse in reset", int'(ref_pulse), 0);
        check("R1", "an_err in reset", int'(an_err), 0);
        @(negedge clk_fb);
        check("R1", "fb_pulse in reset", int'(fb_pulse), 0);
        check("R1", "mod_ctl in reset", int'(mod_ctl), 0);
        @(negedge clk_ref); rst_ref = 1'b0;
        @(negedge clk_fb);  rst_fb  = 1'b0;
        wait_ref(6);
        expect_ref("R1", 1);
        expect_fb("R1", 1, 0);
    endtask

    task automatic t_ref_ratios();
        int rs[3] = '{5, 12, 7};
        foreach (rs[i]) begin
            write_r(rs[i]);
            wait_ref(40);
            expect_ref("R2", rs[i]);
        end
    endtask

    task automatic t_fb_patterns();
        int ns[3] = '{6, 4, 3};
        int as[3] = '{2, 0, 3};
        foreach (ns[i]) begin
            write_an(ns[i], as[i]);
            write_r(7);
            wait_fb(40);
            expect_fb("R5", ns[i], as[i]);
        end
    endtask

    task automatic t_stage_and_illegal();
        write_an(9, 4);
        wait_fb(40);
        expect_fb("R4", 3, 3);
        write_r(3); write_r(0); write_r(4);
        wait_ref(30); wait_fb(40);
        expect_ref("R3", 7);
        expect_fb("R3", 3, 3);
        write_r(7);
        wait_fb(40);
        expect_fb("R4", 9, 4);
        write_an(0, 0);
        write_r(7);
        wait_fb(40);
        expect_fb("R4", 1, 0);
    endtask

    task automatic t_clamp();
        write_an(5, 9);
        check("R6", "an_err after A>N", int'(an_err), 1);
        write_r(7);
        wait_fb(40);
        expect_fb("R6", 5, 5);
        write_an(5, 1);
        check("R6", "an_err after A<=N", int'(an_err), 0);
    endtask

    task automatic t_ref_midcount();
        int per;
        ref_sync();
        wr_r = 1'b1; wr_data = 18'(10);
        per = 1;
        @(negedge clk_ref);
        wr_r = 1'b0;
        while (!ref_pulse) begin per++; @(negedge clk_ref); end
        check("R7", "in-progress ref period", per, 7);
        for (int i = 0; i < 2; i++) begin
            ref_period(per);
            check("R7", "ref period after change", per, 10);
        end
    endtask

    task automatic t_fb_midcount();
        int per[6], mch[6];
        bit switched;
        write_an(6, 2);
        write_r(10);
        wait_fb(40);
        fb_sync();
        fork
            begin
                write_an(4, 3);
                write_r(10);
            end
            begin
                for (int i = 0; i < 6; i++) fb_period(per[i], mch[i]);
            end
        join
        check("R8", "in-progress fb period", per[0], 6);
        check("R8", "in-progress mod_ctl", mch[0], 2);
        switched = 1'b0;
        for (int i = 0; i < 6; i++) begin
            bit is_old, is_new;
            is_old = (per[i] == 6) && (mch[i] == 2);
            is_new = (per[i] == 4) && (mch[i] == 3);
            if (is_new) switched = 1'b1;
            check("R8", "period is whole old or new", int'(is_new || (is_old && !switched)), 1);
        end
        check("R8", "last period new N", per[5], 4);
        check("R8", "last period new A", mch[5], 3);
    endtask

    task automatic t_last_wins();
        ref_sync();
        wr_r = 1'b1; wr_data = 18'(9);
        @(negedge clk_ref);
        wr_data = 18'(6);
        @(negedge clk_ref);
        wr_r = 1'b0;
        wait_ref(30);
        expect_ref("R9", 6);
    endtask

    initial begin
        wait_ref(5);
        t_reset();
        t_ref_ratios();
        t_fb_patterns();
        t_stage_and_illegal();
        t_clamp();
        t_ref_midcount();
        t_fb_midcount();
        t_last_wins();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #900000;
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule